// File: doc/BRIEF.md
# Age-Escalating Request Arbiter

This block picks one request per cycle from a small pending queue inside a memory-side scheduler. In normal operation it orders requests first-ready, then oldest-first. Some requests can only issue when an outside rule marks them eligible, and those requests can wait a long time. To keep them from starving, the block promotes any request that has waited longer than a scaled running average of read latency. A promoted request goes ahead of all other requests.

Each entry presents a valid flag, an eligible flag, a ready flag and an age. The scheduler also feeds in read-completion latency samples. The block keeps an exponential moving average of those samples and uses it to set the urgency threshold. The grant is a combinational one-hot vector. The only state in the block is the latency average, so a sample changes the threshold from the next cycle on.

Top module: `age_escalating_arbiter`

## Requirements
- R1: `grant` has at most one bit set. It is all zero exactly when no entry has both `req_valid` and `req_eligible` high.
- R2: An entry whose `req_valid` or `req_eligible` is low is never granted, whatever its ready flag or age.
- R3: An entry is urgent when its age is strictly greater than the threshold avg + floor(avg/5), where avg is the current latency average. An age equal to the threshold is not urgent.
- R4: If any valid, eligible entry is urgent, the grant goes to an urgent entry, ahead of ready or older non-urgent entries.
- R5: Among urgent candidates, the one with the largest age wins. An age tie goes to the lowest queue index.
- R6: With no urgent candidate, a candidate whose ready flag is high beats one whose ready flag is low. Among ready candidates, the largest age wins and an age tie goes to the lowest index.
- R7: With no urgent and no ready candidate, the candidate with the largest age wins, and an age tie goes to the lowest index.
- R8: While `rst_n` is low, the average is loaded from `init_avg`. After reset it holds that value until the first sample arrives.
- R9: On a clock edge with `lat_valid` high, the average becomes floor((7*avg + lat_sample)/8). The new threshold applies from that edge on. Without `lat_valid`, the average does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_avg | input | 16 | Latency average loaded during reset |
| lat_valid | input | 1 | A read-completion latency sample is present |
| lat_sample | input | 16 | Latency of the completed read, in cycles |
| req_valid | input | 16 | Per-entry occupied flag |
| req_ready | input | 16 | Per-entry first-ready flag |
| req_eligible | input | 16 | Per-entry permission to issue this cycle |
| req_age | input | 256 | Per-entry age; entry i uses bits [16*i+15:16*i] |
| grant | output | 16 | One-hot selected entry, or zero |

## Verification
The latency average update and urgent promotion can meet in the same cycle. The bench provokes this by setting an entry's age exactly at the threshold or one above it, then sending a latency sample. The sample moves the threshold, so the same entry can flip between urgent and non-urgent. The bench recomputes the average itself after every sample and checks the grant against both the old and the new threshold. A long pseudo-random sweep, with ages clustered around the threshold and many ties, is compared against an arithmetic reference of the three priority tiers.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [1:0] {
      TIER_URGENT = 2'd0,
      TIER_READY  = 2'd1,
      TIER_ANY    = 2'd2
   } tier_e;

   localparam int unsigned NUM_TIERS = 3;

   function automatic int unsigned clog2_min1(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction
endpackage

// File: rtl/lat_ema.sv
module lat_ema #(
   parameter int unsigned LAT_W  = 16,
   parameter int unsigned SHIFT  = 3,
   localparam int unsigned THR_W = LAT_W + 1,
   localparam int unsigned SUM_W = LAT_W + SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LAT_W-1:0] init_avg,
   input  logic             lat_valid,
   input  logic [LAT_W-1:0] lat_sample,
   output logic [LAT_W-1:0] avg_o,
   output logic [THR_W-1:0] thr_o
);
   if (SHIFT < 1 || SHIFT > 8) begin : g_bad_shift
      $error("lat_ema: SHIFT out of range");
   end

   localparam logic [SUM_W-1:0] KEEP = SUM_W'((1 << SHIFT) - 1);

   logic [LAT_W-1:0] avg_q;
   logic [SUM_W-1:0] blend;
   logic [SUM_W-1:0] blend_sh;

   always_comb begin
      blend    = SUM_W'(avg_q) * KEEP + SUM_W'(lat_sample);
      blend_sh = blend >> SHIFT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         avg_q <= init_avg;
      else if (lat_valid) avg_q <= blend_sh[LAT_W-1:0];
   end

   assign avg_o = avg_q;
   assign thr_o = THR_W'(avg_q) + THR_W'(avg_q / LAT_W'(5));

   p_avg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!lat_valid && $past(rst_n)) |=> (avg_q == $past(avg_q)));
   p_avg_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_valid && $past(rst_n) && (lat_sample <= avg_q)) |=> (avg_q <= $past(avg_q)));
endmodule

// File: rtl/urgency_flags.sv
module urgency_flags #(
   parameter int unsigned N     = 16,
   parameter int unsigned AGE_W = 16,
   parameter int unsigned THR_W = 17
) (
   input  logic [N*AGE_W-1:0] ages,
   input  logic [THR_W-1:0]   thr,
   output logic [N-1:0]       urgent
);
   localparam int unsigned CMP_W = (AGE_W > THR_W) ? AGE_W : THR_W;

   for (genvar i = 0; i < N; i++) begin : g_entry
      logic [CMP_W-1:0] age_x;
      assign age_x     = CMP_W'(ages[i*AGE_W +: AGE_W]);
      assign urgent[i] = age_x > CMP_W'(thr);
   end
endmodule

// File: rtl/oldest_picker.sv
module oldest_picker #(
   parameter int unsigned N     = 16,
   parameter int unsigned AGE_W = 16,
   localparam int unsigned IDX_W = arb_pkg::clog2_min1(N)
) (
   input  logic [N-1:0]       mask,
   input  logic [N*AGE_W-1:0] ages,
   output logic [N-1:0]       pick,
   output logic               any
);
   logic [IDX_W-1:0] best_idx;
   logic [AGE_W-1:0] best_age;
   logic             found;

   always_comb begin
      best_idx = '0;
      best_age = '0;
      found    = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (mask[i] && (!found || ages[i*AGE_W +: AGE_W] > best_age)) begin
            best_idx = IDX_W'(i);
            best_age = ages[i*AGE_W +: AGE_W];
            found    = 1'b1;
         end
      end
      pick = '0;
      if (found) pick[best_idx] = 1'b1;
      any = found;
   end
endmodule

// File: rtl/age_escalating_arbiter.sv
module age_escalating_arbiter #(
   parameter int unsigned N         = 16,
   parameter int unsigned AGE_W     = 16,
   parameter int unsigned LAT_W     = 16,
   parameter int unsigned EMA_SHIFT = 3,
   localparam int unsigned THR_W    = LAT_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LAT_W-1:0]   init_avg,
   input  logic               lat_valid,
   input  logic [LAT_W-1:0]   lat_sample,
   input  logic [N-1:0]       req_valid,
   input  logic [N-1:0]       req_ready,
   input  logic [N-1:0]       req_eligible,
   input  logic [N*AGE_W-1:0] req_age,
   output logic [N-1:0]       grant
);
   import arb_pkg::*;

   if (N < 2 || N > 64) begin : g_bad_n
      $error("age_escalating_arbiter: N out of range");
   end
   if (AGE_W < 2 || LAT_W < 4) begin : g_bad_w
      $error("age_escalating_arbiter: width too small");
   end

   logic [LAT_W-1:0] avg;
   logic [THR_W-1:0] thr;
   logic [N-1:0]     urgent;
   logic [N-1:0]     cand;
   logic [N-1:0]     tier_mask [NUM_TIERS];
   logic [N-1:0]     tier_pick [NUM_TIERS];
   logic [NUM_TIERS-1:0] tier_any;

   lat_ema #(.LAT_W(LAT_W), .SHIFT(EMA_SHIFT)) u_ema (
      .clk(clk), .rst_n(rst_n), .init_avg(init_avg),
      .lat_valid(lat_valid), .lat_sample(lat_sample),
      .avg_o(avg), .thr_o(thr)
   );

   urgency_flags #(.N(N), .AGE_W(AGE_W), .THR_W(THR_W)) u_urg (
      .ages(req_age), .thr(thr), .urgent(urgent)
   );

   assign cand = req_valid & req_eligible;

   for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
      if (t == int'(TIER_URGENT)) begin : g_u
         assign tier_mask[t] = cand & urgent;
      end else if (t == int'(TIER_READY)) begin : g_r
         assign tier_mask[t] = cand & req_ready;
      end else begin : g_a
         assign tier_mask[t] = cand;
      end
      oldest_picker #(.N(N), .AGE_W(AGE_W)) u_pick (
         .mask(tier_mask[t]), .ages(req_age),
         .pick(tier_pick[t]), .any(tier_any[t])
      );
   end

   always_comb begin
      grant = '0;
      for (int t = NUM_TIERS - 1; t >= 0; t--) begin
         if (tier_any[t]) grant = tier_pick[t];
      end
   end

   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   p_grant_when_cand_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cand != '0) |-> (grant != '0));
   p_no_ineligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & ~cand) == '0));
   p_urgent_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((cand & urgent) != '0) |-> ((grant & urgent) != '0));
   p_ready_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (((cand & urgent) == '0) && ((cand & req_ready) != '0)) |-> ((grant & req_ready) != '0));
endmodule

// File: tb/test_age_escalating_arbiter.sv
module test_age_escalating_arbiter;
   localparam int N = 16;
   localparam int AW = 16;
   localparam time PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] init_avg = 16'd100;
   logic lat_valid = 1'b0;
   logic [15:0] lat_sample = '0;
   logic [N-1:0] req_valid = '0, req_ready = '0, req_eligible = '0;
   logic [N*AW-1:0] req_age = '0;
   logic [N-1:0] grant;

   int n_chk = 0, n_bad = 0;
   int m_avg;
   int ages [N];
   logic [31:0] rs = 32'h1234_5678;

   always #(PERIOD/2) clk = ~clk;

   age_escalating_arbiter i_age_escalating_arbiter (
      .clk(clk), .rst_n(rst_n), .init_avg(init_avg), .lat_valid(lat_valid),
      .lat_sample(lat_sample), .req_valid(req_valid), .req_ready(req_ready),
      .req_eligible(req_eligible), .req_age(req_age), .grant(grant));

   function automatic int thr_of(input int a);
      return a + a / 5;
   endfunction

   function automatic logic [N-1:0] ref_grant();
      int best; int tier; int bt;
      best = -1; bt = 3;
      for (int i = 0; i < N; i++) begin
         if (req_valid[i] && req_eligible[i]) begin
            tier = (ages[i] > thr_of(m_avg)) ? 0 : (req_ready[i] ? 1 : 2);
            if (tier < bt || (tier == bt && ages[i] > ages[best])) begin
               bt = tier; best = i;
            end
         end
      end
      ref_grant = '0;
      if (best >= 0) ref_grant[best] = 1'b1;
   endfunction

   task automatic apply_ages();
      for (int i = 0; i < N; i++) req_age[i*AW +: AW] = AW'(ages[i]);
   endtask

   task automatic check(input string req);
      logic [N-1:0] exp;
      #1;
      exp = ref_grant();
      n_chk++;
      if (grant !== exp) begin
         n_bad++;
         $display("FAIL %s: grant=%h expected=%h (avg=%0d)", req, grant, exp, m_avg);
      end
   endtask

   task automatic sample(input int s);
      @(negedge clk);
      lat_valid = 1'b1; lat_sample = 16'(s);
      @(posedge clk);
      m_avg = (7 * m_avg + s) / 8;
      @(negedge clk);
      lat_valid = 1'b0;
   endtask

   function automatic int rnd();
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      return int'(rs[30:0]);
   endfunction

   task automatic clear();
      req_valid = '0; req_ready = '0; req_eligible = '0;
      for (int i = 0; i < N; i++) ages[i] = 0;
      apply_ages();
   endtask

   task automatic edge_probe(input string req, input int delta);
      // entry 3 non-ready with age at threshold + delta, entry 9 ready and young
      clear();
      req_valid[3] = 1; req_eligible[3] = 1; ages[3] = thr_of(m_avg) + delta;
      req_valid[9] = 1; req_eligible[9] = 1; req_ready[9] = 1; ages[9] = 1;
      apply_ages();
      check(req);
   endtask

   initial begin
      bit done;
      done = 0;
      m_avg = 100;
      for (int i = 0; i < N; i++) ages[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state, nothing pending -> zero grant
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check("R8");
      // R8: init value 100 gives threshold 120; equal is not urgent, 121 is
      edge_probe("R8", 0);
      edge_probe("R8", 1);

      // R2: single entry, all combinations of valid/eligible/ready
      for (int i = 0; i < N; i++) begin
         for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            clear();
            req_valid[i] = c[0]; req_eligible[i] = c[1]; req_ready[i] = c[2];
            ages[i] = 500; apply_ages();
            check("R2");
         end
      end

      // R3/R9: threshold edges as the average moves
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         edge_probe("R3", 0);
         edge_probe("R3", 1);
         sample(40 + k * 97);
         edge_probe("R9", 0);
         edge_probe("R9", 1);
         edge_probe("R9", -1);
      end

      // R9: idle cycles leave the average alone
      repeat (5) @(posedge clk);
      @(negedge clk);
      edge_probe("R9", 0);
      edge_probe("R9", 1);

      // R5/R6/R7: ties resolve to lowest index
      @(negedge clk);
      clear();
      req_valid = '1; req_eligible = '1;
      for (int i = 0; i < N; i++) ages[i] = 7;
      apply_ages();
      check("R7");
      req_ready = 16'hA0A0; check("R6");
      for (int i = 0; i < N; i++) ages[i] = (i % 5 == 2) ? 60000 : 7;
      apply_ages(); check("R5");

      // R4-R7 sweep with ages clustered around the threshold
      for (int v = 0; v < 3000; v++) begin
         if (v % 250 == 0) sample(rnd() % 900);
         @(negedge clk);
         for (int i = 0; i < N; i++) begin
            int r;
            r = rnd();
            req_valid[i] = (r % 5) != 0;
            req_eligible[i] = ((r >> 4) % 4) != 0;
            req_ready[i] = ((r >> 8) % 3) == 0;
            if (((r >> 12) % 2) == 0) ages[i] = thr_of(m_avg) - 2 + ((r >> 14) % 5);
            else ages[i] = (r >> 14) % 8;
            if (ages[i] < 0) ages[i] = 0;
            if (ages[i] > 65535) ages[i] = 65535;
         end
         apply_ages();
         check("R4/R5/R6/R7");
      end

      // R3: saturated age against large average never exceeds threshold
      sample(65535); sample(65535);
      for (int k = 0; k < 30; k++) sample(65535);
      @(negedge clk);
      clear();
      req_valid[0] = 1; req_eligible[0] = 1; req_ready[0] = 1; ages[0] = 1;
      req_valid[5] = 1; req_eligible[5] = 1; ages[5] = 65535;
      apply_ages();
      check("R3");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule